// File: doc/BRIEF.md
# Reset request collector and arbiter

This block gathers reset requests from hardware and presents one request at a time to the reset controller. Each request carries a cause code and a vector of the sources that were taken. Conditional sources only count when their enable bit is set. An escalation request and a main-power glitch count no matter what the enables hold. The glitch is signalled by the active-low main-power-good input dropping, and that input passes through a two-flop synchronizer before use.

Requests are taken on the rising edge of each qualified source. A source held high therefore causes one reset, not a stream of them. Requests are accepted whether the system is active or already serving something else, and they accumulate until they can be served. A wakeup strobe competes with resets for the same output channel. Wakeups and resets are served one at a time, in order of arrival. When both arrive in the same cycle, the wakeup is served first and the reset is kept pending until the controller acknowledges the wakeup.

While a request is outstanding, the clock-enable output is low. It returns high in the cycle after the acknowledge. Two status outputs record the last hardware reset taken: one holds the conditional and glitch sources, and a separate bit records escalation.

Top module: `rstreq_arbiter`

## Requirements
- R1: After reset, `rst_req_o`=0, `rst_cause_o`=0, `rst_vec_o`=0, `clk_en_o`=1, and both status outputs are 0.
- R2: A rising conditional request bit i with enable bit i set produces, on the next clock edge, `rst_req_o`=1, cause 2 (hardware) and `rst_vec_o` bit i. With the enable bit clear, no request is issued.
- R3: Escalation (vector bit N_COND) and main-power glitch (vector bit N_COND+1, taken when `mainpwr_ok_i` is low) cause a hardware reset whatever the enable bits hold.
- R4: During a hardware reset, `rst_vec_o` equals the enabled conditional bits plus the unconditional bits that rose together. It stays stable until `rst_ack_i`, and the cycle after the acknowledge has `rst_req_o`=0.
- R5: `rst_status_o` holds the conditional bits in [N_COND-1:0] and the glitch bit in [N_COND] of the last hardware reset. `esc_status_o` is 1 exactly when that reset included escalation. Both hold after the acknowledge.
- R6: A wakeup strobe alone produces cause 1 (wake) with `rst_vec_o`=0.
- R7: A wakeup and a reset arriving in the same cycle are served wakeup first, then the reset, after one active cycle; the reset is not lost.
- R8: A request that arrives while another is being served is kept pending and served after the acknowledge, in order of arrival.
- R9: `clk_en_o` is 0 whenever a request is outstanding and 1 otherwise.
- R10: The glitch input passes two synchronizer flops, so a low level first appears as a request on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_req_i | input | N_COND | Conditional reset request levels |
| cond_en_i | input | N_COND | Per-source enable for the conditional requests |
| esc_req_i | input | 1 | Escalation reset request (unmaskable) |
| mainpwr_ok_i | input | 1 | Main power good; low means a glitch (unmaskable) |
| wake_req_i | input | 1 | Wakeup pending strobe |
| rst_ack_i | input | 1 | Acknowledge from the reset controller |
| rst_req_o | output | 1 | Request outstanding |
| rst_cause_o | output | 2 | 0 none, 1 wake, 2 hardware request |
| rst_vec_o | output | N_COND+2 | Taken sources: conditional, then escalation, then glitch |
| clk_en_o | output | 1 | Clock enable, low while a request is outstanding |
| rst_status_o | output | N_COND+1 | Last hardware reset: conditional bits and glitch bit |
| esc_status_o | output | 1 | Last hardware reset included escalation |

## Verification
The assertions take for granted that the reset controller raises `rst_ack_i` only while a request is outstanding, and that new rising edges of a source served earlier do not arrive faster than the acknowledge loop can drain them. The stimulus keeps to this. Every request is dropped in the cycle it is observed on the outputs. The acknowledge is a single-cycle pulse given only while `rst_req_o` is high. Competing wakeups and resets are placed at chosen cycle offsets: the same cycle, during a wakeup service, or during a reset service.

// File: rtl/rra_pkg.sv
package rra_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_WAKE = 2'd1,
        CAUSE_HW   = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_WAKE   = 2'd1,
        ST_RESET  = 2'd2
    } serve_e;

endpackage

// File: rtl/rra_sync2.sv
module rra_sync2 #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RESET_VAL}};
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rra_qualify.sv
module rra_qualify #(
    parameter int N_COND = 4,
    localparam int W     = N_COND + 2
) (
    input  logic [N_COND-1:0] cond_req_i,
    input  logic [N_COND-1:0] cond_en_i,
    input  logic              esc_i,
    input  logic              glitch_i,
    output logic [W-1:0]      vec_o
);
    for (genvar i = 0; i < N_COND; i++) begin : g_mask
        assign vec_o[i] = cond_req_i[i] & cond_en_i[i];
    end
    assign vec_o[N_COND]   = esc_i;
    assign vec_o[N_COND+1] = glitch_i;
endmodule

// File: rtl/rra_order.sv
module rra_order
    import rra_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    input  logic         wake_i,
    input  logic         ack_i,
    output logic         valid_o,
    output cause_e       cause_o,
    output logic [W-1:0] vec_o,
    output logic         clk_en_o
);
    typedef struct packed {
        serve_e       state;
        logic [W-1:0] vec;
        logic [W-1:0] prev;
        logic [W-1:0] acc;
        logic         wake;
        logic         older;
    } ord_t;

    ord_t s_d, s_q;
    logic [W-1:0] rise, acc_n;
    logic         wake_n, older_n;

    always_comb begin
        rise    = lvl_i & ~s_q.prev;
        acc_n   = s_q.acc | rise;
        wake_n  = s_q.wake | wake_i;
        older_n = s_q.older;
        if (s_q.acc == '0) begin
            older_n = (rise != '0) && !(s_q.wake || wake_i);
        end

        s_d       = s_q;
        s_d.prev  = lvl_i;
        s_d.acc   = acc_n;
        s_d.wake  = wake_n;
        s_d.older = older_n;

        unique case (s_q.state)
            ST_ACTIVE: begin
                if (acc_n != '0 && (older_n || !wake_n)) begin
                    s_d.state = ST_RESET;
                    s_d.vec   = acc_n;
                    s_d.acc   = '0;
                    s_d.older = 1'b0;
                end else if (wake_n) begin
                    s_d.state = ST_WAKE;
                    s_d.wake  = 1'b0;
                end
            end
            ST_WAKE: begin
                if (ack_i) s_d.state = ST_ACTIVE;
            end
            ST_RESET: begin
                if (ack_i) begin
                    s_d.state = ST_ACTIVE;
                    s_d.vec   = '0;
                end
            end
            default: s_d.state = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: ST_ACTIVE, vec: '0, prev: '0, acc: '0,
                     wake: 1'b0, older: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o  = (s_q.state != ST_ACTIVE);
    assign clk_en_o = (s_q.state == ST_ACTIVE);
    assign vec_o    = s_q.vec;
    always_comb begin
        unique case (s_q.state)
            ST_WAKE:  cause_o = CAUSE_WAKE;
            ST_RESET: cause_o = CAUSE_HW;
            default:  cause_o = CAUSE_NONE;
        endcase
    end

    AST_HW_VEC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_RESET) |-> (s_q.vec != '0)); // R2
    AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_RESET && !ack_i) |=> (s_q.state == ST_RESET && $stable(s_q.vec))); // R4
    AST_ACK_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state != ST_ACTIVE && ack_i) |=> (s_q.state == ST_ACTIVE)); // R4
    AST_WAKE_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_WAKE) |-> (s_q.vec == '0)); // R6
    AST_PENDING_NOT_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_ACTIVE && (s_q.acc != '0 || s_q.wake)) |=> (s_q.state != ST_ACTIVE)); // R7
    AST_SERVE_NO_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state != ST_ACTIVE && !ack_i) |=> $stable(s_q.state)); // R8
endmodule

// File: rtl/rstreq_arbiter.sv
module rstreq_arbiter
    import rra_pkg::*;
#(
    parameter int N_COND    = 4,
    parameter int SYNC_FLOPS = 2,
    localparam int W        = N_COND + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_COND-1:0] cond_req_i,
    input  logic [N_COND-1:0] cond_en_i,
    input  logic              esc_req_i,
    input  logic              mainpwr_ok_i,
    input  logic              wake_req_i,
    input  logic              rst_ack_i,
    output logic              rst_req_o,
    output logic [1:0]        rst_cause_o,
    output logic [W-1:0]      rst_vec_o,
    output logic              clk_en_o,
    output logic [N_COND:0]   rst_status_o,
    output logic              esc_status_o
);
    typedef struct packed {
        logic [N_COND:0] hw;
        logic            esc;
    } stat_t;

    logic          pwr_ok_s;
    logic [W-1:0]  lvl;
    cause_e        cause;
    stat_t         st_d, st_q;

    rra_sync2 #(.STAGES(SYNC_FLOPS), .RESET_VAL(1'b1)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (mainpwr_ok_i),
        .q_o   (pwr_ok_s)
    );

    rra_qualify #(.N_COND(N_COND)) i_qual (
        .cond_req_i(cond_req_i),
        .cond_en_i (cond_en_i),
        .esc_i     (esc_req_i),
        .glitch_i  (~pwr_ok_s),
        .vec_o     (lvl)
    );

    rra_order #(.W(W)) i_order (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_i   (lvl),
        .wake_i  (wake_req_i),
        .ack_i   (rst_ack_i),
        .valid_o (rst_req_o),
        .cause_o (cause),
        .vec_o   (rst_vec_o),
        .clk_en_o(clk_en_o)
    );

    assign rst_cause_o = cause;

    always_comb begin
        st_d = st_q;
        if (cause == CAUSE_HW) begin
            st_d.hw  = {rst_vec_o[N_COND+1], rst_vec_o[N_COND-1:0]};
            st_d.esc = rst_vec_o[N_COND];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_status_o = st_q.hw;
    assign esc_status_o = st_q.esc;

    AST_ESC_STATUS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_cause_o == CAUSE_HW) |=> (esc_status_o == $past(rst_vec_o[N_COND]))); // R5
    AST_CLK_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> $fell(clk_en_o)); // R9
endmodule

// File: tb/test_rstreq_arbiter.sv
module test_rstreq_arbiter;
    localparam int N = 4;
    localparam int W = N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, en = '0;
    logic esc = 1'b0, pok = 1'b1, wake = 1'b0, ack = 1'b0;
    logic rq, cke, escst;
    logic [1:0] cause;
    logic [W-1:0] vec;
    logic [N:0] stat;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rstreq_arbiter #(.N_COND(N)) i_rstreq_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .cond_req_i(req), .cond_en_i(en),
        .esc_req_i(esc), .mainpwr_ok_i(pok), .wake_req_i(wake), .rst_ack_i(ack),
        .rst_req_o(rq), .rst_cause_o(cause), .rst_vec_o(vec), .clk_en_o(cke),
        .rst_status_o(stat), .esc_status_o(escst)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // request outstanding: valid, clk enable low, cause, vector
    task automatic chk_out(input string tag, input logic [1:0] c, input logic [W-1:0] v);
        chk({tag, " valid"}, 32'(rq), 32'(c != 2'd0));
        chk({tag, " R9 clk_en"}, 32'(cke), 32'(c == 2'd0));
        chk({tag, " cause"}, 32'(cause), 32'(c));
        chk({tag, " vec"}, 32'(vec), 32'(v));
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_out("R1", 2'd0, '0);
        chk("R1 status", 32'(stat), 0);
        chk("R1 esc status", 32'(escst), 0);

        // R2/R4/R5 sweep of enable masks against request patterns
        for (int m = 0; m < 16; m++) begin
            for (int p = 1; p < 16; p++) begin
                en = m[N-1:0];
                req = p[N-1:0];
                tick();
                e = W'(m & p);
                req = '0;
                if (e != '0) begin
                    chk_out("R2 masked request", 2'd2, e);
                    tick();
                    chk_out("R4 vec held", 2'd2, e);
                    do_ack();
                    chk_out("R4 after ack", 2'd0, '0);
                    chk("R5 status", 32'(stat), 32'(e[N-1:0]));
                    chk("R5 esc status", 32'(escst), 0);
                end else begin
                    tick();
                    tick();
                    chk_out("R2 disabled ignored", 2'd0, '0);
                end
            end
        end

        // R3 escalation with enables cleared
        en = '0;
        esc = 1'b1;
        req = '1;
        tick();
        esc = 1'b0;
        req = '0;
        chk_out("R3 escalation", 2'd2, W'(1) << N);
        do_ack();
        chk("R5 esc status set", 32'(escst), 1);
        chk("R5 status no cond", 32'(stat), 0);

        // R3/R10 glitch through synchronizer
        pok = 1'b0;
        tick();
        tick();
        chk_out("R10 not before third edge", 2'd0, '0);
        tick();
        chk_out("R3 glitch", 2'd2, W'(1) << (N + 1));
        pok = 1'b1;
        tick();
        tick();
        do_ack();
        chk("R5 glitch status", 32'(stat), 32'(1) << N);
        chk("R5 esc cleared", 32'(escst), 0);
        tick();
        chk_out("R3 glitch single", 2'd0, '0);

        // R4 combined vector: enabled cond plus escalation
        en = 4'b0101;
        req = 4'b1111;
        esc = 1'b1;
        tick();
        req = '0;
        esc = 1'b0;
        chk_out("R4 combined", 2'd2, W'(6'h15));
        do_ack();
        chk("R5 combined status", 32'(stat), 32'h5);
        chk("R5 combined esc", 32'(escst), 1);

        // R6 wake alone
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk_out("R6 wake", 2'd1, '0);
        do_ack();
        chk_out("R6 after ack", 2'd0, '0);
        chk("R6 status untouched", 32'(stat), 32'h5);

        // R7 simultaneous: wake first, reset after one active cycle
        en = '1;
        wake = 1'b1;
        req = 4'b0001;
        tick();
        wake = 1'b0;
        req = '0;
        chk_out("R7 wake first", 2'd1, '0);
        do_ack();
        chk_out("R7 gap active", 2'd0, '0);
        tick();
        chk_out("R7 reset second", 2'd2, W'(1));
        do_ack();

        // R8 reset first, wake arrives during reset service
        req = 4'b0010;
        tick();
        req = '0;
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk_out("R8 reset kept", 2'd2, W'(2));
        do_ack();
        tick();
        chk_out("R8 wake after reset", 2'd1, '0);
        do_ack();

        // R8 wake served, reset then wake arrive during it
        wake = 1'b1;
        tick();
        wake = 1'b0;
        req = 4'b0100;
        tick();
        req = '0;
        wake = 1'b1;
        tick();
        wake = 1'b0;
        do_ack();
        tick();
        chk_out("R8 older reset first", 2'd2, W'(4));
        do_ack();
        tick();
        chk_out("R8 later wake second", 2'd1, '0);
        do_ack();

        // R8 during reset service: wake then reset, wake first afterwards
        req = 4'b0001;
        tick();
        req = '0;
        wake = 1'b1;
        tick();
        wake = 1'b0;
        req = 4'b1000;
        tick();
        req = '0;
        do_ack();
        tick();
        chk_out("R8 earlier wake first", 2'd1, '0);
        do_ack();
        tick();
        chk_out("R8 later reset second", 2'd2, W'(8));
        do_ack();
        tick();
        chk_out("R9 idle at end", 2'd0, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule